// File: doc/BRIEF.md
# I2C Register Target with Skip-Wrap Pointer

This block is an I2C target that connects to the two open-drain bus lines. It samples them on a faster system clock. Behind the bus it holds thirteen byte-wide registers, numbered 0 to 12. Locations 0 to 2 are configuration registers that the bus master can write, and host logic reads them back in parallel. Locations 3 to 12 hold read-only data that host logic loads as one block through a sample port.

A bus master addresses the block with the fixed 7-bit address 0011110. In a write, the first byte after the address sets an internal register pointer. Every later byte is stored at that pointer. In a read, bytes come out starting at the pointer. After each data byte the pointer moves on, but not in a straight line: the step from 8 goes back to 3, and any byte handled at 12 or higher sends the pointer to 0. A repeated start keeps the pointer, so a master can set the pointer and then read from that place. The pointer is never visible on the bus.

The sample port uses a valid/ready handshake. The host keeps `smp_valid` high and holds `smp_data` steady until it sees `smp_ready`. A load happens on a clock where both are high. The block pulls `smp_ready` low for the whole of a read transaction, so a burst of reads never mixes bytes from two different samples.

Top module: `i2c_wrapreg_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits are 0011110. Bit 0 of that byte selects read (1, byte 0x3D) or write (0, byte 0x3C). For any other address it gives no acknowledge and ignores every bus bit until the next start condition.
- R2: The block treats SDA falling while SCL is high as a start condition and SDA rising while SCL is high as a stop condition. It only ever pulls SDA low through `sda_oe`, and it changes `sda_oe` only while SCL is low.
- R3: In a write transaction, the first byte after the address loads the pointer. Each later byte is written to the register the pointer selects. The block acknowledges every byte it receives.
- R4: After each data byte, read or written, handled at pointer value p, the pointer becomes 0 when p is 12 or more, becomes 3 when p is 8, and otherwise becomes p+1.
- R5: A repeated start begins a new address phase and keeps the current pointer value.
- R6: Read data leaves MSB first. An acknowledge from the master on the ninth clock sends the next byte. A not-acknowledge ends the data, and SDA stays released until the next start.
- R7: Configuration bits come out on `cfg_data` as {reg2, reg1, reg0}. Reg0 defines all 8 bits, reg1 defines bits 7:5, and reg2 defines bits 1:0. Undefined bits read as 0 and ignore writes. The reset values are 0x10, 0x20 and 0x03.
- R8: Reading any location from 13 to 255 returns 0x00. Writes to locations 3 to 255 have no effect.
- R9: On a clock where `smp_valid` and `smp_ready` are both high, byte k of `smp_data` (bits 8k+7:8k) is loaded into register 3+k. `smp_ready` is low from the acknowledge of a read address until the next start or stop. Data registers reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| smp_valid | input | 1 | Host offers a new data sample |
| smp_ready | output | 1 | Block can take a sample now |
| smp_data | input | 80 | Sample bytes; byte k goes to register 3+k |
| cfg_data | output | 24 | Configuration registers {reg2, reg1, reg0} |

## Verification
The bench checks the pointer at its bends. A read burst starting at 7 must return registers 7, 8, 3 and 4; a design that counted straight through would return 9 instead of 3. A write burst starting at 12 must land its second byte in register 0; a design that did not wrap would let it vanish or spill into location 13. Masked bits, writes to read-only and invalid locations, and reads above 12 are all read back, which exposes a design that stored a don't-care bit or returned stale data. A foreign address followed by data must leave the configuration untouched. A sample offered during a read must wait until the stop; a design that loaded it early would change the burst partway through.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam int NUM_CFG = 3;
  localparam int NUM_DAT = 10;
  localparam int NUM_REG = NUM_CFG + NUM_DAT;
  localparam int PTR_LAST    = NUM_REG - 1;
  localparam int PTR_SKIP_AT = 9;
  localparam int PTR_SKIP_TO = 3;
  localparam logic [6:0] DEV_ADDR = 7'b0011110;
  // per-register defined-bit masks and reset values, index 0 = reg0
  localparam logic [NUM_CFG-1:0][DW-1:0] CFG_MASK = {8'h03, 8'hE0, 8'hFF};
  localparam logic [NUM_CFG-1:0][DW-1:0] CFG_RST  = {8'h03, 8'h20, 8'h10};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RXPTR,
    ST_RXDAT,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_st_t;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], line_i};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/i2cw_ptr_step.sv
module i2cw_ptr_step #(
  parameter int AW      = 8,
  parameter int LAST    = 12,
  parameter int SKIP_AT = 9,
  parameter int SKIP_TO = 3
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (cur >= AW'(LAST))           nxt = '0;
    else if (cur == AW'(SKIP_AT-1)) nxt = AW'(SKIP_TO);
    else                            nxt = cur + 1'b1;
  end
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
  import i2cw_pkg::*;
#(
  parameter int NCFG = NUM_CFG,
  parameter int NDAT = NUM_DAT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 ld_en,
  input  logic [NDAT*DW-1:0]   ld_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NCFG*DW-1:0]   cfg_flat
);
  localparam int NREG = NCFG + NDAT;

  logic [NREG-1:0][DW-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) regs[i] <= CFG_RST[i] & CFG_MASK[i];
      for (int j = 0; j < NDAT; j++) regs[NCFG+j] <= '0;
    end else begin
      for (int i = 0; i < NCFG; i++)
        if (wr_en && wr_addr == AW'(i)) regs[i] <= wr_data & CFG_MASK[i];
      if (ld_en)
        for (int j = 0; j < NDAT; j++) regs[NCFG+j] <= ld_data[j*DW +: DW];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = regs[i];
  end

  genvar g;
  generate
    for (g = 0; g < NCFG; g++) begin : g_cfg_out
      assign cfg_flat[g*DW +: DW] = regs[g];
    end
  endgenerate
endmodule

// File: rtl/i2c_wrapreg_target.sv
module i2c_wrapreg_target
  import i2cw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [NUM_DAT*DW-1:0]   smp_data,
  output logic [NUM_CFG*DW-1:0]   cfg_data
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  i2cw_line_sync #(.STAGES(2)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));
  i2cw_line_sync #(.STAGES(2)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  logic start_det, stop_det;
  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  bus_st_t       st, ack_to;
  logic [3:0]    bcnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic [AW-1:0] ptr, ptr_nxt;
  logic [DW-1:0] rd_data;
  logic          ack_drv, m_ack, rd_busy;

  logic evt_ok, byte_in, ptr_load, wr_en, tx_load, ptr_adv;
  assign evt_ok   = ~start_det & ~stop_det;
  assign byte_in  = evt_ok & scl_fall & (bcnt == 4'd8);
  assign ptr_load = byte_in & (st == ST_RXPTR);
  assign wr_en    = byte_in & (st == ST_RXDAT);
  assign tx_load  = evt_ok & scl_fall &
                    (((st == ST_ACK) & (ack_to == ST_TX)) | ((st == ST_MACK) & m_ack));
  assign ptr_adv  = wr_en | tx_load;

  i2cw_ptr_step #(
    .AW(AW), .LAST(PTR_LAST), .SKIP_AT(PTR_SKIP_AT), .SKIP_TO(PTR_SKIP_TO)
  ) u_step (.cur(ptr), .nxt(ptr_nxt));

  i2cw_regfile #(.NCFG(NUM_CFG), .NDAT(NUM_DAT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx_sh),
    .ld_en(smp_valid & smp_ready), .ld_data(smp_data),
    .rd_addr(ptr), .rd_data(rd_data), .cfg_flat(cfg_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ptr_load) ptr <= rx_sh;
    else if (ptr_adv)  ptr <= ptr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ack_to <= ST_IDLE; bcnt <= '0;
      rx_sh <= '0; tx_sh <= '0; ack_drv <= 1'b0; m_ack <= 1'b0; rd_busy <= 1'b0;
    end else if (start_det) begin
      st <= ST_ADDR; bcnt <= '0; ack_drv <= 1'b0; rd_busy <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; ack_drv <= 1'b0; rd_busy <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR, ST_RXPTR, ST_RXDAT: begin
          if (scl_rise && bcnt != 4'd8) begin
            rx_sh <= {rx_sh[DW-2:0], sda_lvl};
            bcnt  <= bcnt + 4'd1;
          end else if (byte_in) begin
            bcnt <= '0;
            if (st == ST_ADDR) begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                ack_drv <= 1'b1;
                st      <= ST_ACK;
                rd_busy <= rx_sh[0];
                ack_to  <= rx_sh[0] ? ST_TX : ST_RXPTR;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              ack_drv <= 1'b1;
              st      <= ST_ACK;
              ack_to  <= ST_RXDAT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            ack_drv <= 1'b0;
            bcnt    <= '0;
            st      <= ack_to;
            if (tx_load) tx_sh <= rd_data;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              st <= ST_MACK;
            end else begin
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
              bcnt  <= bcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) m_ack <= ~sda_lvl;
          else if (scl_fall) begin
            bcnt <= '0;
            if (tx_load) begin
              tx_sh <= rd_data;
              st    <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe    = ack_drv | ((st == ST_TX) & ~tx_sh[DW-1]);
  assign smp_ready = ~rd_busy;
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
  import i2cw_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic                  smp_ready,
  input logic [NUM_CFG*DW-1:0] cfg_data,
  input logic                  wr_en,
  input logic                  ptr_adv,
  input logic [AW-1:0]         ptr,
  input logic                  rd_busy
);
  p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_cfg_only_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data != $past(cfg_data)) |-> $past(wr_en));

  p_never_lands_nine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ptr_adv) |-> (ptr != AW'(PTR_SKIP_AT)));

  p_top_wraps_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr_adv) && ($past(ptr) >= AW'(PTR_LAST))) |-> (ptr == '0));

  p_no_sample_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> !smp_ready);
endmodule

bind i2c_wrapreg_target i2cw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .smp_ready(smp_ready), .cfg_data(cfg_data), .wr_en(wr_en),
  .ptr_adv(ptr_adv), .ptr(ptr), .rd_busy(rd_busy));

// File: tb/test_i2c_wrapreg_target.sv
module test_i2c_wrapreg_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, smp_valid, smp_ready;
  logic [79:0] smp_data;
  logic [23:0] cfg_data;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] rb [4];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_wrapreg_target i_i2c_wrapreg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .cfg_data(cfg_data));

  // pointer, write byte, expected readback, requirement number
  localparam logic [27:0] VEC [0:8] = '{
    {8'd0,  8'hA5, 8'hA5, 4'd7},
    {8'd1,  8'hFF, 8'hE0, 4'd7},
    {8'd2,  8'hFF, 8'h03, 4'd7},
    {8'd2,  8'h00, 8'h00, 4'd7},
    {8'd1,  8'h5A, 8'h40, 4'd7},
    {8'd20, 8'h77, 8'h00, 4'd8},
    {8'd5,  8'h12, 8'h32, 4'd8},
    {8'd12, 8'h99, 8'h39, 4'd8},
    {8'd0,  8'h3C, 8'h3C, 4'd7}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(output logic v);
    q(); scl = 1'b1; q(); v = sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      pulse(v);
    end
    sda_m = 1'b1;
    pulse(v);
    ack = ~v;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic v;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      pulse(v);
      d[i] = v;
    end
    sda_m = ~mack;
    pulse(v);
    sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] p, input logic [7:0] d [4], input int n, output logic ok);
    logic a;
    ok = 1'b1;
    bus_start();
    send_byte(8'h3C, a); ok &= a;
    send_byte(p, a); ok &= a;
    for (int i = 0; i < n; i++) begin send_byte(d[i], a); ok &= a; end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, output logic ok);
    logic a;
    ok = 1'b1;
    bus_start();
    send_byte(8'h3C, a); ok &= a;
    send_byte(p, a); ok &= a;
    bus_start();
    send_byte(8'h3D, a); ok &= a;
    for (int i = 0; i < n; i++) read_byte(i != n-1, rb[i]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] wd [4];
    smp_valid = 1'b0;
    for (int k = 0; k < 10; k++) smp_data[k*8 +: 8] = 8'h30 + 8'(k);
    repeat (3) @(negedge clk);
    // reset state: R7 reset values, idle bus, R9 ready
    chk("R7 reset cfg", 32'(cfg_data), 32'h032010);
    chk("R2 reset sda_oe", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset ready", 32'(smp_ready), 1);
    rd_txn(8'd3, 1, ok);
    chk("R9 data reset zero", 32'(rb[0]), 0);

    // R9 sample load
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    rd_txn(8'd3, 2, ok);
    chk("R9 load reg3", 32'(rb[0]), 32'h30);
    chk("R9 load reg4", 32'(rb[1]), 32'h31);
    chk("R1 ack on 3C/3D", 32'(ok), 1);

    // table walk: write one byte, read it back after repeated start (R5)
    for (int v = 0; v < 9; v++) begin
      wd[0] = VEC[v][19:12];
      wr_txn(VEC[v][27:20], wd, 1, ok);
      chk("R3 write acked", 32'(ok), 1);
      rd_txn(VEC[v][27:20], 1, ok);
      chk($sformatf("R%0d vec %0d", VEC[v][3:0], v), 32'(rb[0]), 32'(VEC[v][11:4]));
    end
    chk("R7 cfg after table", 32'(cfg_data), 32'h00403C);

    // R4 skip from 8 back to 3
    rd_txn(8'd7, 4, ok);
    chk("R4 burst @7", 32'(rb[0]), 32'h34);
    chk("R4 burst @8", 32'(rb[1]), 32'h35);
    chk("R4 skip to 3", 32'(rb[2]), 32'h30);
    chk("R4 then 4", 32'(rb[3]), 32'h31);

    // R4 wrap after 12
    rd_txn(8'd11, 3, ok);
    chk("R4 burst @11", 32'(rb[0]), 32'h38);
    chk("R4 burst @12", 32'(rb[1]), 32'h39);
    chk("R4 wrap to 0", 32'(rb[2]), 32'h3C);

    // R6 NACK ends, pointer kept past stop (R5)
    rd_txn(8'd4, 1, ok);
    chk("R6 single read", 32'(rb[0]), 32'h31);
    chk("R6 released after nack", 32'(sda_oe), 0);
    bus_start();
    send_byte(8'h3D, a);
    read_byte(1'b0, rb[0]);
    bus_stop();
    chk("R5 pointer kept", 32'(rb[0]), 32'h32);

    // R3 write burst across cfg into read-only
    wd = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_txn(8'd0, wd, 4, ok);
    chk("R3 burst acked", 32'(ok), 1);
    chk("R3 burst cfg", 32'(cfg_data), 32'h032011);
    rd_txn(8'd3, 1, ok);
    chk("R8 reg3 untouched", 32'(rb[0]), 32'h30);

    // R4 write wrap at 12
    wd = '{8'hAA, 8'h5B, 8'h00, 8'h00};
    wr_txn(8'd12, wd, 2, ok);
    chk("R4 write wrap", 32'(cfg_data), 32'h03205B);

    // R1 foreign addresses
    bus_start();
    send_byte(8'h40, a);
    chk("R1 no ack 0x40", 32'(a), 0);
    send_byte(8'h00, a);
    send_byte(8'hFF, a);
    chk("R1 ignored data", 32'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'h3F, a);
    chk("R1 no ack 0x3F", 32'(a), 0);
    bus_stop();
    chk("R1 cfg unchanged", 32'(cfg_data), 32'h03205B);

    // R9 back-pressure during read
    bus_start();
    send_byte(8'h3D, a);
    chk("R2 addr ack", 32'(a), 1);
    chk("R9 busy in read", 32'(smp_ready), 0);
    for (int k = 0; k < 10; k++) smp_data[k*8 +: 8] = 8'h50 + 8'(k);
    smp_valid = 1'b1;
    read_byte(1'b0, rb[0]);
    chk("R9 burst data old", 32'(rb[0]), 32'h20);
    chk("R9 still busy", 32'(smp_ready), 0);
    bus_stop();
    q();
    chk("R9 ready after stop", 32'(smp_ready), 1);
    smp_valid = 1'b0;
    rd_txn(8'd3, 1, ok);
    chk("R9 new sample", 32'(rb[0]), 32'h50);
    rd_txn(8'd200, 1, ok);
    chk("R8 high read zero", 32'(rb[0]), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule